// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two numbers held in redundant signed-digit form, where every digit is -1, 0 or +1, and returns an (N+1)-digit result in the same form. It is fully combinational. No carry ripples along the word, so the logic depth stays the same whatever the width.

The addition is split into three stages. A one-bit reference digit is derived for each position from the digit pair one place below. From that, each position produces a one-bit intermediate carry, which goes upward, and a one-bit intermediate sum. A final digitwise merge then adds the carry that arrives at each position to the sum held there. The carry digits lie in {0, +1} and the sum digits lie in {-1, 0}, so the merge can never overflow.

A parameter chooses how the stages are grouped: three separate stages, the first two fused, or a single step in which every result digit is a direct function of six operand digits. All three groupings return bit-identical words.

Top module: `sd_carryfree_add`

## Requirements
- R1: Each digit uses two bits, with the digit at position i in bits 2i+1:2i. The code 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1. The result word never contains the code 2'b10.
- R2: An operand digit coded 2'b10 is read as 0. The result is the same as when that digit is coded 2'b00.
- R3: The value of the (N+1)-digit result, the sum of digit times 2^i, equals the value of operand a plus the value of operand b.
- R4: The reference digit r(0) is 0. For 0 <= i < N, r(i+1) is 1 exactly when the digit pair at position i sums to a negative number.
- R5: With p(i) the pair sum at position i, z(i) = p(i) - r(i) + 2*r(i+1). The intermediate carry c(i+1) is 1 exactly when z(i) >= 1. The intermediate sum s(i) is -1 when z(i) is odd and 0 otherwise.
- R6: For i < N, result digit i equals c(i) + s(i), with c(0) = 0. The lowest result digit is therefore never +1.
- R7: Result digit N equals c(N) - r(N). When both top operand digits are -1, the top result digit is -1.
- R8: The three stage groupings (FUSE = 0, 1, 2) give identical result words for every input.
- R9: The block has no state. The result follows the operands within the same time step, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2*N | First operand, two bits per digit, lowest digit in bits 1:0 |
| b_i | input | 2*N | Second operand, same layout as a_i |
| sum_o | output | 2*N+2 | Result of N+1 digits, same layout |

## Verification
A wrong reference or intermediate digit does not always change the numeric value. It can instead show up as a different but still valid digit pattern, or as a digit coded 2'b10 in the result. Because the block has no state, any such fault appears at sum_o in the same time step as the operands that trigger it. The bench therefore compares every result word exactly against a digit-level model built from R4 to R7, and separately checks the numeric sum. Exhaustive three-digit runs cover every pair combination, including illegal input codes, at every neighbouring position.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;

    typedef logic [1:0] sd_code_t;

    localparam sd_code_t SD_ZERO = 2'b00;
    localparam sd_code_t SD_POS  = 2'b01;
    localparam sd_code_t SD_NEG  = 2'b11;

    // numeric value of one digit code; the unused code reads as zero
    function automatic int sd_val(sd_code_t c);
        if (!c[0]) return 0;
        return c[1] ? -1 : 1;
    endfunction

    // reference bit: set when the digit pair below sums negative
    function automatic logic ref_bit(sd_code_t a, sd_code_t b);
        return (sd_val(a) + sd_val(b)) < 0;
    endfunction

    // transfer-adjusted pair value, always in -1..2
    function automatic int zval(sd_code_t a, sd_code_t b, logic r_lo, logic r_hi);
        return sd_val(a) + sd_val(b) - int'(r_lo) + 2 * int'(r_hi);
    endfunction

    function automatic logic carry_of(int z);
        return z > 0;
    endfunction

    function automatic logic odd_of(int z);
        return (z == 1) || (z == -1);
    endfunction

    // digit value carry minus negative-sum flag, encoded
    function automatic sd_code_t digit_code(logic up, logic dn);
        if (up && !dn) return SD_POS;
        if (!up && dn) return SD_NEG;
        return SD_ZERO;
    endfunction

endpackage

// File: rtl/sdadd_ref_gen.sv
module sdadd_ref_gen
    import sdadd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] a_i,
    input  logic [2*N-1:0] b_i,
    output logic [N:0]     ref_o
);

    always_comb begin
        ref_o[0] = 1'b0;
        for (int i = 0; i < N; i++) begin
            ref_o[i+1] = ref_bit(a_i[2*i +: 2], b_i[2*i +: 2]);
        end
    end

    genvar g;
    for (g = 0; g < N; g++) begin : g_chk
        always_comb begin
            if (ref_o[g+1]) begin
                // R4: a set reference needs a -1 in the pair below
                a_r4_ref_needs_neg: assert (a_i[2*g +: 2] == SD_NEG || b_i[2*g +: 2] == SD_NEG)
                    else $error("reference set without a negative digit below");
            end
        end
    end

endmodule

// File: rtl/sdadd_split.sv
module sdadd_split
    import sdadd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] a_i,
    input  logic [2*N-1:0] b_i,
    input  logic [N:0]     ref_i,
    output logic [N:0]     carry_o,
    output logic [N-1:0]   sneg_o
);

    always_comb begin
        carry_o[0] = 1'b0;
        for (int i = 0; i < N; i++) begin
            int z;
            z = zval(a_i[2*i +: 2], b_i[2*i +: 2], ref_i[i], ref_i[i+1]);
            carry_o[i+1] = carry_of(z);
            sneg_o[i]    = odd_of(z);
        end
    end

    genvar g;
    for (g = 0; g < N; g++) begin : g_chk
        always_comb begin
            // R5: carry and sum together keep the adjusted pair value
            a_r5_split_keeps_value: assert (2 * int'(carry_o[g+1]) - int'(sneg_o[g]) ==
                    sd_val(a_i[2*g +: 2]) + sd_val(b_i[2*g +: 2]) - int'(ref_i[g]) + 2 * int'(ref_i[g+1]))
                else $error("intermediate split lost value at a position");
        end
    end

endmodule

// File: rtl/sdadd_fused_split.sv
module sdadd_fused_split
    import sdadd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] a_i,
    input  logic [2*N-1:0] b_i,
    output logic [N:0]     carry_o,
    output logic [N-1:0]   sneg_o,
    output logic           rtop_o
);

    always_comb begin
        logic r_lo;
        logic r_hi;
        int   z;
        r_lo       = 1'b0;
        carry_o[0] = 1'b0;
        for (int i = 0; i < N; i++) begin
            r_hi         = ref_bit(a_i[2*i +: 2], b_i[2*i +: 2]);
            z            = zval(a_i[2*i +: 2], b_i[2*i +: 2], r_lo, r_hi);
            carry_o[i+1] = carry_of(z);
            sneg_o[i]    = odd_of(z);
            r_lo         = r_hi;
        end
        rtop_o = r_lo;
    end

endmodule

// File: rtl/sdadd_merge.sv
module sdadd_merge
    import sdadd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N:0]     carry_i,
    input  logic [N-1:0]   sneg_i,
    input  logic           rtop_i,
    output logic [2*N+1:0] sum_o
);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            sum_o[2*i +: 2] = digit_code(carry_i[i], sneg_i[i]);
        end
        sum_o[2*N +: 2] = digit_code(carry_i[N], rtop_i);
    end

    always_comb begin
        // R6: nothing carries into the lowest position
        a_r6_low_digit_nonpos: assert (sum_o[1:0] != SD_POS)
            else $error("lowest result digit is +1");
    end

endmodule

// File: rtl/sdadd_onestep.sv
module sdadd_onestep
    import sdadd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] a_i,
    input  logic [2*N-1:0] b_i,
    output logic [2*N+1:0] sum_o
);

    // each digit is a function of the pairs at i, i-1 and i-2
    always_comb begin
        int   p0;
        int   p1;
        int   p2;
        logic up;
        logic dn;
        p1 = 0;
        p2 = 0;
        for (int i = 0; i < N; i++) begin
            p0 = sd_val(a_i[2*i +: 2]) + sd_val(b_i[2*i +: 2]);
            up = carry_of(p1 - int'(p2 < 0) + 2 * int'(p1 < 0));
            dn = odd_of(p0 - int'(p1 < 0) + 2 * int'(p0 < 0));
            sum_o[2*i +: 2] = digit_code(up, dn);
            p2 = p1;
            p1 = p0;
        end
        up = carry_of(p1 - int'(p2 < 0) + 2 * int'(p1 < 0));
        sum_o[2*N +: 2] = digit_code(up, p1 < 0);
    end

endmodule

// File: rtl/sd_carryfree_add.sv
module sd_carryfree_add
    import sdadd_pkg::*;
#(
    parameter int N    = 8,
    parameter int FUSE = 0
) (
    input  logic [2*N-1:0] a_i,
    input  logic [2*N-1:0] b_i,
    output logic [2*N+1:0] sum_o
);

    localparam int DW = 2 * N + 2;

    if (FUSE == 0) begin : g_three
        logic [N:0]   ref_d;
        logic [N:0]   carry_d;
        logic [N-1:0] sneg_d;
        sdadd_ref_gen #(.N(N)) u_ref (.a_i(a_i), .b_i(b_i), .ref_o(ref_d));
        sdadd_split   #(.N(N)) u_split (.a_i(a_i), .b_i(b_i), .ref_i(ref_d),
                                        .carry_o(carry_d), .sneg_o(sneg_d));
        sdadd_merge   #(.N(N)) u_merge (.carry_i(carry_d), .sneg_i(sneg_d),
                                        .rtop_i(ref_d[N]), .sum_o(sum_o));
    end else if (FUSE == 1) begin : g_two
        logic [N:0]   carry_d;
        logic [N-1:0] sneg_d;
        logic         rtop_d;
        sdadd_fused_split #(.N(N)) u_fsplit (.a_i(a_i), .b_i(b_i), .carry_o(carry_d),
                                            .sneg_o(sneg_d), .rtop_o(rtop_d));
        sdadd_merge       #(.N(N)) u_merge (.carry_i(carry_d), .sneg_i(sneg_d),
                                            .rtop_i(rtop_d), .sum_o(sum_o));
    end else begin : g_one
        sdadd_onestep #(.N(N)) u_one (.a_i(a_i), .b_i(b_i), .sum_o(sum_o));
    end

    always_comb begin
        for (int i = 0; i < DW / 2; i++) begin
            // R1: the unused code never leaves the block
            a_r1_legal_code: assert (sum_o[2*i +: 2] != 2'b10)
                else $error("illegal digit code in result");
        end
        // R7: top digit sign follows the top operand pair
        if (sum_o[2*N +: 2] == SD_POS) begin
            a_r7_top_pos: assert (a_i[2*N-1 -: 2] != SD_NEG && b_i[2*N-1 -: 2] != SD_NEG)
                else $error("top digit +1 with a negative top operand digit");
        end
        if (sum_o[2*N +: 2] == SD_NEG) begin
            a_r7_top_neg: assert (a_i[2*N-1 -: 2] == SD_NEG || b_i[2*N-1 -: 2] == SD_NEG)
                else $error("top digit -1 without a negative top operand digit");
        end
    end

    if (N <= 30) begin : g_value_chk
        always_comb begin
            longint va;
            longint vr;
            va = 0;
            vr = 0;
            for (int i = 0; i < N; i++) begin
                va = va + (longint'(sd_val(a_i[2*i +: 2]) + sd_val(b_i[2*i +: 2])) <<< i);
            end
            for (int i = 0; i <= N; i++) begin
                vr = vr + (longint'(sd_val(sum_o[2*i +: 2])) <<< i);
            end
            // R3: the digit word keeps the numeric sum
            a_r3_value_kept: assert (vr == va)
                else $error("result value differs from operand sum");
        end
    end

endmodule

// File: tb/sim_sd_carryfree_add.sv
module sim_sd_carryfree_add;

    localparam int NW = 8;
    localparam int NS = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [2*NW-1:0] wa = '0, wb = '0;
    logic [2*NW+1:0] w0, w1, w2;
    logic [2*NS-1:0] sa = '0, sb = '0;
    logic [2*NS+1:0] s0, s1, s2;

    sd_carryfree_add #(.N(NW), .FUSE(0)) u0 (.a_i(wa), .b_i(wb), .sum_o(w0));
    sd_carryfree_add #(.N(NW), .FUSE(1)) u1 (.a_i(wa), .b_i(wb), .sum_o(w1));
    sd_carryfree_add #(.N(NW), .FUSE(2)) u2 (.a_i(wa), .b_i(wb), .sum_o(w2));
    sd_carryfree_add #(.N(NS), .FUSE(0)) u_s0 (.a_i(sa), .b_i(sb), .sum_o(s0));
    sd_carryfree_add #(.N(NS), .FUSE(1)) u_s1 (.a_i(sa), .b_i(sb), .sum_o(s1));
    sd_carryfree_add #(.N(NS), .FUSE(2)) u_s2 (.a_i(sa), .b_i(sb), .sum_o(s2));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    function automatic int dv(logic [1:0] c);
        case (c)
            2'b01:   return 1;
            2'b11:   return -1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] ec(int v);
        if (v > 0) return 2'b01;
        if (v < 0) return 2'b11;
        return 2'b00;
    endfunction

    function automatic longint wval(logic [33:0] w, int nd);
        longint acc = 0;
        for (int i = 0; i < nd; i++) acc += longint'(dv(w[2*i +: 2])) * (longint'(1) << i);
        return acc;
    endfunction

    // digit model written from R4, R5, R6, R7
    function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b, int n);
        int p [17];
        bit r [18];
        bit c [18];
        bit sn [17];
        logic [33:0] out = '0;
        r[0] = 0;
        for (int i = 0; i < n; i++) begin
            p[i]   = dv(a[2*i +: 2]) + dv(b[2*i +: 2]);
            r[i+1] = p[i] < 0;
        end
        c[0] = 0;
        for (int i = 0; i < n; i++) begin
            int z;
            z       = p[i] - int'(r[i]) + 2 * int'(r[i+1]);
            c[i+1]  = z >= 1;
            sn[i]   = (z % 2) != 0;
        end
        for (int i = 0; i < n; i++) out[2*i +: 2] = ec(int'(c[i]) - int'(sn[i]));
        out[2*n +: 2] = ec(int'(c[n]) - int'(r[n]));
        return out;
    endfunction

    function automatic logic [1:0] rand_code();
        case ($urandom % 3)
            0:       return 2'b00;
            1:       return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    task automatic chk(string tag, logic [33:0] got, logic [33:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_val(string tag, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_wide(string tag);
        logic [33:0] exp;
        exp = model({16'b0, wa}, {16'b0, wb}, NW);
        chk({tag, " R4,R5,R6,R7 digits"}, {16'b0, w0}, exp);
        chk({tag, " R8 fuse1"}, {16'b0, w1}, {16'b0, w0});
        chk({tag, " R8 fuse2"}, {16'b0, w2}, {16'b0, w0});
        chk_val({tag, " R3 value"}, wval({16'b0, w0}, NW + 1),
                wval({18'b0, wa}, NW) + wval({18'b0, wb}, NW));
    endtask

    task automatic drive_wide(logic [2*NW-1:0] a, logic [2*NW-1:0] b);
        @(posedge clk);
        wa = a;
        wb = b;
        @(negedge clk);
    endtask

    task automatic t_zero();
        drive_wide('0, '0);
        chk("R1,R3 zero operands", {16'b0, w0}, 34'b0);
        check_wide("zero");
    endtask

    task automatic t_exhaustive_small();
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                logic [33:0] exp;
                int bad;
                @(posedge clk);
                sa = 6'(x);
                sb = 6'(y);
                @(negedge clk);
                exp = model({26'b0, sa}, {26'b0, sb}, NS);
                chk("small R4,R5,R6,R7 digits", {26'b0, s0}, exp);
                chk("small R8 fuse1", {26'b0, s1}, {26'b0, s0});
                chk("small R8 fuse2", {26'b0, s2}, {26'b0, s0});
                // R2: code 10 reads as zero in the decoded operand sum
                chk_val("small R2,R3 value", wval({26'b0, s0}, NS + 1),
                        wval({28'b0, sa}, NS) + wval({28'b0, sb}, NS));
                bad = 0;
                for (int i = 0; i <= NS; i++) if (s0[2*i +: 2] == 2'b10) bad++;
                chk_val("small R1 no 10 code", longint'(bad), 0);
            end
        end
    endtask

    task automatic t_random_wide();
        for (int k = 0; k < 2000; k++) begin
            logic [2*NW-1:0] a, b;
            for (int i = 0; i < NW; i++) begin
                a[2*i +: 2] = rand_code();
                b[2*i +: 2] = rand_code();
            end
            drive_wide(a, b);
            check_wide("random");
        end
    endtask

    task automatic t_extremes();
        drive_wide({NW{2'b01}}, {NW{2'b01}});
        check_wide("all plus");
        chk_val("R3 all plus value", wval({16'b0, w0}, NW + 1), 510);
        drive_wide({NW{2'b11}}, {NW{2'b11}});
        check_wide("all minus");
        chk_val("R3 all minus value", wval({16'b0, w0}, NW + 1), -510);
        chk("R7 top digit negative", {32'b0, w0[2*NW +: 2]}, 34'b11);
        drive_wide({NW{2'b01}}, {NW{2'b11}});
        check_wide("cancel");
        chk("R3 cancel zero word", {16'b0, w0}, 34'b0);
    endtask

    task automatic t_single_neg();
        for (int k = 0; k < NW; k++) begin
            logic [2*NW-1:0] a = '0;
            a[2*k +: 2] = 2'b11;
            drive_wide(a, '0);
            check_wide("single minus R4");
            chk("R6 low digit not plus", {32'b0, w0[1:0] == 2'b01}, 34'b0);
        end
    endtask

    task automatic t_illegal_code();
        for (int k = 0; k < 50; k++) begin
            logic [2*NW-1:0] a, b, ac;
            logic [2*NW+1:0] ref_word;
            for (int i = 0; i < NW; i++) begin
                a[2*i +: 2] = ($urandom % 2 == 0) ? 2'b10 : rand_code();
                b[2*i +: 2] = rand_code();
                ac[2*i +: 2] = (a[2*i +: 2] == 2'b10) ? 2'b00 : a[2*i +: 2];
            end
            drive_wide(ac, b);
            ref_word = w0;
            drive_wide(a, b);
            chk("R2 code 10 same as 00", {16'b0, w0}, {16'b0, ref_word});
        end
    endtask

    task automatic t_comb();
        logic [2*NW-1:0] a;
        @(negedge clk);
        #1;
        for (int i = 0; i < NW; i++) a[2*i +: 2] = rand_code();
        wa = a;
        wb = {NW{2'b01}};
        #1;
        chk("R9 follows without edge", {16'b0, w0}, model({16'b0, wa}, {16'b0, wb}, NW));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        t_zero();
        t_exhaustive_small();
        t_random_wide();
        t_extremes();
        t_single_neg();
        t_illegal_code();
        t_comb();
        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end

endmodule